// File: doc/BRIEF.md
# String Operation Sequencer

This block carries out one string primitive per start pulse: block move, compare, scan against the accumulator, load into the accumulator, or store from the accumulator. Each primitive works on bytes or 16-bit words. It can run once or under a repeat prefix. The repeat prefix can run unconditionally, keep going only while the operands match, or keep going only while they differ. On a start pulse the caller presents the source and destination segment:offset pairs, the repeat count, the accumulator and the direction setting. The block then drives a single-request memory port until the work is finished.

Each memory request forms a 20-bit physical address as segment times sixteen plus offset. Source reads use the source pair and destination accesses use the destination pair. After each iteration the block steps only the offsets that the primitive uses. Under a prefix it counts the repeat register down, and on compare and scan it records the outcome flags. A one-clock done pulse marks the end of the work. The updated offsets, count, accumulator and flags stay on the outputs until the next start.

Top module: `strop_seq`

## Requirements
- R1: After reset `busy`, `done`, `mem_req`, `flag_cf`, `flag_zf` and `flag_sf` are all 0.
- R2: After each iteration, each offset the primitive uses moves by 1 for a byte operation (`is_word`=0) or by 2 for a word operation (`is_word`=1). It moves up when `dir_down`=0 and down when `dir_down`=1.
- R3: `mem_addr` equals segment*16 + offset, taken modulo 2^20. On a word transfer, bits 7:0 of the data belong to `mem_addr` and bits 15:8 belong to `mem_addr`+1.
- R4: Move (`op`=0) reads at the source and writes that data at the destination, and steps both offsets.
- R5: Load (`op`=3) reads at the source into `acc`. A byte load replaces only `acc[7:0]`. Only the source offset steps.
- R6: Store (`op`=4) writes `acc` (only its low byte for a byte store) at the destination. Only the destination offset steps.
- R7: Compare (`op`=1) takes the destination operand away from the source operand, and scan (`op`=2) takes it away from the accumulator. Both compare as unsigned numbers and do not write memory. When the first operand is greater the flags are cf=0, zf=0, sf=0. When it is less they are cf=1, zf=0, sf=1. When the operands are equal they are cf=0, zf=1, sf=0. Scan steps only the destination offset.
- R8: With no prefix (`rep_mode`=0) exactly one iteration runs and `count` keeps the value of `count_in`.
- R9: With any prefix (`rep_mode`=1,2,3) each iteration lowers `count` by 1, and work stops once it reaches 0.
- R10: On compare and scan, `rep_mode`=2 also stops after an iteration that leaves zf=0, and `rep_mode`=3 also stops after one that leaves zf=1. `rep_mode`=1 ignores zf.
- R11: A prefixed start with `count_in`=0 makes no memory request and raises `done` one clock after the start.
- R12: A request keeps `mem_req`, `mem_addr` and `mem_we` steady until `mem_ready` is seen. `done` is high for exactly one clock, in the same cycle that the final offsets, count and flags appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a primitive; sampled only while idle |
| op | input | 3 | 0 move, 1 compare, 2 scan, 3 load, 4 store |
| is_word | input | 1 | 1 word, 0 byte |
| rep_mode | input | 2 | 0 none, 1 repeat, 2 repeat while equal, 3 repeat while different |
| dir_down | input | 1 | 1 offsets step downward |
| src_seg | input | 16 | Source segment |
| src_off_in | input | 16 | Source starting offset |
| dst_seg | input | 16 | Destination segment |
| dst_off_in | input | 16 | Destination starting offset |
| count_in | input | 16 | Repeat count |
| acc_in | input | 16 | Accumulator value |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_word | output | 1 | Transfer size, 1 word |
| mem_addr | output | 20 | Physical address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Request completes this clock |
| busy | output | 1 | A primitive is in progress |
| done | output | 1 | One-clock completion pulse |
| src_off | output | 16 | Current source offset |
| dst_off | output | 16 | Current destination offset |
| count | output | 16 | Current repeat count |
| acc | output | 16 | Accumulator |
| flag_cf | output | 1 | Borrow flag from last compare |
| flag_zf | output | 1 | Equality flag from last compare |
| flag_sf | output | 1 | Less-than flag from last compare |

## Verification
Single-shot moves, loads and stores go in both directions and at both sizes. Because these runs use distinct byte values, a swapped byte lane, a wrong step size or a pointer that should not move shows up clearly. Three compare cases with values chosen as greater, less and equal (one of them with the top bit set) separate unsigned ordering from a sign-based one. Prefixed compare and scan strings are built so that the match or mismatch falls on a known middle element. The final count and offsets then show the iteration where the work stopped, and an all-matching scan under the unconditional prefix shows that zf does not cut that prefix short. A zero-count start, a store that crosses the 20-bit address wrap and a slow memory that delays ready cover the remaining edges.

// File: rtl/strop_pkg.sv
package strop_pkg;
  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_CMP   = 3'd1,
    OP_SCAN  = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4
  } strop_op_e;

  typedef enum logic [1:0] {
    RP_NONE     = 2'd0,
    RP_ALL      = 2'd1,
    RP_WHILE_EQ = 2'd2,
    RP_WHILE_NE = 2'd3
  } strop_rep_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SRC  = 2'd1,
    ST_DST  = 2'd2
  } strop_state_e;

  function automatic strop_state_e entry_phase(strop_op_e o);
    return (o == OP_SCAN || o == OP_STORE) ? ST_DST : ST_SRC;
  endfunction
endpackage

// File: rtl/strop_agen.sv
module strop_agen #(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = 20
) (
  input  logic [OFF_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  input  logic             down,
  input  logic             word,
  output logic [PA_W-1:0]  phys,
  output logic [OFF_W-1:0] off_next
);
  logic [PA_W-1:0]  base;
  logic [OFF_W-1:0] step;

  always_comb begin
    base     = PA_W'(seg) << SEG_SHIFT;
    phys     = base + PA_W'(off);
    step     = word ? OFF_W'(2) : OFF_W'(1);
    off_next = down ? (off - step) : (off + step);
  end
endmodule

// File: rtl/strop_cmp.sv
module strop_cmp #(
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic              word,
  output logic              cf,
  output logic              zf,
  output logic              sf
);
  logic [DATA_W-1:0] lhs_m, rhs_m;

  always_comb begin
    lhs_m = word ? lhs : DATA_W'(lhs[BYTE_W-1:0]);
    rhs_m = word ? rhs : DATA_W'(rhs[BYTE_W-1:0]);
    cf    = lhs_m < rhs_m;
    zf    = lhs_m == rhs_m;
    sf    = lhs_m < rhs_m;
  end
endmodule

// File: rtl/strop_seq.sv
module strop_seq
  import strop_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = 20,
  parameter int BYTE_W    = 8,
  localparam int DATA_W   = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic              is_word,
  input  logic [1:0]        rep_mode,
  input  logic              dir_down,
  input  logic [OFF_W-1:0]  src_seg,
  input  logic [OFF_W-1:0]  src_off_in,
  input  logic [OFF_W-1:0]  dst_seg,
  input  logic [OFF_W-1:0]  dst_off_in,
  input  logic [OFF_W-1:0]  count_in,
  input  logic [DATA_W-1:0] acc_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_word,
  output logic [PA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done,
  output logic [OFF_W-1:0]  src_off,
  output logic [OFF_W-1:0]  dst_off,
  output logic [OFF_W-1:0]  count,
  output logic [DATA_W-1:0] acc,
  output logic              flag_cf,
  output logic              flag_zf,
  output logic              flag_sf
);
  strop_state_e state_q;
  strop_op_e    op_q;
  strop_rep_e   rep_q;
  logic         word_q, down_q, done_q;
  logic [OFF_W-1:0]  sseg_q, dseg_q, si_q, di_q, cx_q;
  logic [DATA_W-1:0] acc_q, hold_q;
  logic         cf_q, zf_q, sf_q;

  logic [PA_W-1:0]  src_pa, dst_pa;
  logic [OFF_W-1:0] si_nx, di_nx, cx_dec;
  logic [DATA_W-1:0] cmp_lhs;
  logic c_cf, c_zf, c_sf;
  logic xfer, last_ph, uses_src, uses_dst, is_cmp, zf_stop, again, op_ok;

  // offset stepping and physical address for both streams
  strop_agen #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .PA_W(PA_W)) u_src_agen (
    .seg(sseg_q), .off(si_q), .down(down_q), .word(word_q),
    .phys(src_pa), .off_next(si_nx)
  );
  strop_agen #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .PA_W(PA_W)) u_dst_agen (
    .seg(dseg_q), .off(di_q), .down(down_q), .word(word_q),
    .phys(dst_pa), .off_next(di_nx)
  );

  strop_cmp #(.BYTE_W(BYTE_W)) u_cmp (
    .lhs(cmp_lhs), .rhs(mem_rdata), .word(word_q),
    .cf(c_cf), .zf(c_zf), .sf(c_sf)
  );

  always_comb begin
    op_ok    = op <= 3'd4;
    uses_src = (op_q == OP_MOVE) || (op_q == OP_CMP) || (op_q == OP_LOAD);
    uses_dst = (op_q != OP_LOAD);
    is_cmp   = (op_q == OP_CMP) || (op_q == OP_SCAN);
    cmp_lhs  = (op_q == OP_CMP) ? hold_q : acc_q;
    xfer     = (state_q != ST_IDLE) && mem_ready;
    last_ph  = (state_q == ST_DST) || (op_q == OP_LOAD);
    cx_dec   = (rep_q != RP_NONE) ? (cx_q - OFF_W'(1)) : cx_q;
    zf_stop  = is_cmp && (((rep_q == RP_WHILE_EQ) && !c_zf) ||
                          ((rep_q == RP_WHILE_NE) && c_zf));
    again    = (rep_q != RP_NONE) && (cx_dec != '0) && !zf_stop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= OP_MOVE;
      rep_q   <= RP_NONE;
      word_q  <= 1'b0;
      down_q  <= 1'b0;
      done_q  <= 1'b0;
      sseg_q  <= '0;
      dseg_q  <= '0;
      si_q    <= '0;
      di_q    <= '0;
      cx_q    <= '0;
      acc_q   <= '0;
      hold_q  <= '0;
      cf_q    <= 1'b0;
      zf_q    <= 1'b0;
      sf_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start && op_ok) begin
          op_q   <= strop_op_e'(op);
          rep_q  <= strop_rep_e'(rep_mode);
          word_q <= is_word;
          down_q <= dir_down;
          sseg_q <= src_seg;
          dseg_q <= dst_seg;
          si_q   <= src_off_in;
          di_q   <= dst_off_in;
          cx_q   <= count_in;
          acc_q  <= acc_in;
          if ((rep_mode != 2'd0) && (count_in == '0)) done_q <= 1'b1;
          else state_q <= entry_phase(strop_op_e'(op));
        end
      end else if (xfer) begin
        if (!last_ph) begin
          hold_q  <= mem_rdata;
          state_q <= ST_DST;
        end else begin
          if (uses_src) si_q <= si_nx;
          if (uses_dst) di_q <= di_nx;
          cx_q <= cx_dec;
          if (op_q == OP_LOAD)
            acc_q <= word_q ? mem_rdata : {acc_q[DATA_W-1:BYTE_W], mem_rdata[BYTE_W-1:0]};
          if (is_cmp) begin
            cf_q <= c_cf;
            zf_q <= c_zf;
            sf_q <= c_sf;
          end
          if (again) state_q <= entry_phase(op_q);
          else begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
      end
    end
  end

  // request decode from registered state
  always_comb begin
    mem_req   = (state_q != ST_IDLE);
    mem_we    = (state_q == ST_DST) && ((op_q == OP_MOVE) || (op_q == OP_STORE));
    mem_word  = word_q;
    mem_addr  = (state_q == ST_SRC) ? src_pa : dst_pa;
    mem_wdata = (op_q == OP_MOVE) ? hold_q : acc_q;
    busy      = (state_q != ST_IDLE);
    done      = done_q;
    src_off   = si_q;
    dst_off   = di_q;
    count     = cx_q;
    acc       = acc_q;
    flag_cf   = cf_q;
    flag_zf   = zf_q;
    flag_sf   = sf_q;
  end
endmodule

// File: rtl/strop_seq_chk.sv
module strop_seq_chk #(
  parameter int OFF_W = 16,
  parameter int PA_W  = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [1:0]       rep_mode,
  input logic [OFF_W-1:0] count_in,
  input logic             busy,
  input logic             done,
  input logic             mem_req,
  input logic             mem_ready,
  input logic             mem_we,
  input logic [PA_W-1:0]  mem_addr,
  input logic [OFF_W-1:0] count,
  input logic             flag_cf,
  input logic             flag_zf
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R1
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(flag_cf && flag_zf)); // R7
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (rep_mode != 2'd0) && (count_in == '0)) |=> (done && !busy)); // R11
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !$stable(count)) |-> (count == $past(count) - OFF_W'(1))); // R9
endmodule

bind strop_seq strop_seq_chk #(.OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .rep_mode(rep_mode), .count_in(count_in),
  .busy(busy), .done(done), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .count(count),
  .flag_cf(flag_cf), .flag_zf(flag_zf)
);

// File: tb/strop_seq_tb.sv
`timescale 1ns/1ps
module strop_seq_tb;
  localparam logic [2:0] K_MOVE = 3'd0, K_CMP = 3'd1, K_SCAN = 3'd2, K_LOAD = 3'd3, K_STORE = 3'd4;
  localparam logic [1:0] P_NONE = 2'd0, P_ALL = 2'd1, P_EQ = 2'd2, P_NE = 2'd3;

  logic clk = 0, rst = 1, start = 0;
  logic [2:0] op = 0;
  logic is_word = 0, dir_down = 0;
  logic [1:0] rep_mode = 0;
  logic [15:0] src_seg = 0, src_off_in = 0, dst_seg = 0, dst_off_in = 0, count_in = 0, acc_in = 0;
  logic mem_req, mem_we, mem_word, mem_ready;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic busy, done, flag_cf, flag_zf, flag_sf;
  logic [15:0] src_off, dst_off, count, acc;

  int n_chk = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0, hold_err = 0, lat = 0, wait_cnt = 0, last_cyc = 0;
  logic [19:0] last_addr = 0, prev_addr = 0;
  logic prev_wait = 0;
  logic [7:0] mem [0:1023];

  always #5 clk = ~clk;

  strop_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .is_word(is_word), .rep_mode(rep_mode),
    .dir_down(dir_down), .src_seg(src_seg), .src_off_in(src_off_in), .dst_seg(dst_seg),
    .dst_off_in(dst_off_in), .count_in(count_in), .acc_in(acc_in), .mem_req(mem_req),
    .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .done(done),
    .src_off(src_off), .dst_off(dst_off), .count(count), .acc(acc),
    .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_sf(flag_sf)
  );

  // memory model: byte array, word = low byte at addr, high at addr+1
  always @(posedge clk) begin
    if (rst) begin
      mem_ready <= 0; mem_rdata <= 0; wait_cnt <= 0; prev_wait <= 0;
    end else begin
      if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_err <= hold_err + 1;
      prev_wait <= mem_req && !mem_ready;
      prev_addr <= mem_addr;
      if (mem_ready) begin
        mem_ready <= 0;
        wait_cnt  <= 0;
        last_addr <= mem_addr;
        if (mem_we) begin
          n_wr <= n_wr + 1;
          mem[mem_addr[9:0]] <= mem_wdata[7:0];
          if (mem_word) mem[mem_addr[9:0] + 10'd1] <= mem_wdata[15:8];
        end else n_rd <= n_rd + 1;
      end else if (mem_req) begin
        if (wait_cnt >= lat) begin
          mem_ready <= 1;
          mem_rdata <= {mem[mem_addr[9:0] + 10'd1], mem[mem_addr[9:0]]};
        end else wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic go(input logic [2:0] o, input logic w, input logic [1:0] rp, input logic dn,
                    input logic [15:0] ss, input logic [15:0] si, input logic [15:0] ds,
                    input logic [15:0] di, input logic [15:0] cx, input logic [15:0] a);
    @(negedge clk);
    op = o; is_word = w; rep_mode = rp; dir_down = dn; src_seg = ss; src_off_in = si;
    dst_seg = ds; dst_off_in = di; count_in = cx; acc_in = a; start = 1;
    @(negedge clk);
    start = 0;
    last_cyc = 1;
    while (!done && last_cyc < 2000) begin
      @(negedge clk);
      last_cyc++;
    end
  endtask

  task automatic t_reset;
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "mem_req", mem_req, 0);
    check("R1", "flags", {flag_cf, flag_zf, flag_sf}, 0);
  endtask

  task automatic t_move_byte;
    int w0 = n_wr;
    mem[10'h105] = 8'hA5; mem[10'h208] = 8'h00;
    go(K_MOVE, 0, P_NONE, 0, 16'h0010, 16'h0005, 16'h0020, 16'h0008, 16'h0007, 0);
    @(negedge clk);
    check("R4", "moved byte", mem[10'h208], 8'hA5);
    check("R2", "src up byte", src_off, 16'h0006);
    check("R2", "dst up byte", dst_off, 16'h0009);
    check("R8", "count kept", count, 16'h0007);
    check("R4", "write count", n_wr - w0, 1);
    check("R12", "done one clock", done, 0);
  endtask

  task automatic t_move_word_rep;
    lat = 3;
    mem[10'h120] = 8'h11; mem[10'h121] = 8'h22; mem[10'h11E] = 8'h33;
    mem[10'h11F] = 8'h44; mem[10'h11C] = 8'h55; mem[10'h11D] = 8'h66;
    go(K_MOVE, 1, P_ALL, 1, 16'h0010, 16'h0020, 16'h0020, 16'h0040, 16'h0003, 0);
    lat = 0;
    check("R4", "word0", {mem[10'h241], mem[10'h240]}, 16'h2211);
    check("R4", "word1", {mem[10'h23F], mem[10'h23E]}, 16'h4433);
    check("R4", "word2", {mem[10'h23D], mem[10'h23C]}, 16'h6655);
    check("R2", "src down word", src_off, 16'h001A);
    check("R2", "dst down word", dst_off, 16'h003A);
    check("R9", "count to zero", count, 0);
  endtask

  task automatic t_load;
    mem[10'h130] = 8'h34; mem[10'h131] = 8'h12;
    go(K_LOAD, 1, P_NONE, 0, 16'h0010, 16'h0030, 16'h0020, 16'h0077, 16'h0001, 16'h0000);
    check("R3", "word byte order", acc, 16'h1234);
    check("R5", "src step", src_off, 16'h0032);
    check("R5", "dst untouched", dst_off, 16'h0077);
    mem[10'h140] = 8'h5A;
    go(K_LOAD, 0, P_NONE, 1, 16'h0010, 16'h0040, 16'h0020, 16'h0077, 16'h0001, 16'hBEEF);
    check("R5", "byte load keeps high", acc, 16'hBE5A);
    check("R2", "src down byte", src_off, 16'h003F);
  endtask

  task automatic t_store;
    int w0 = n_wr;
    go(K_STORE, 1, P_NONE, 1, 16'h0010, 16'h0099, 16'h0020, 16'h0050, 16'h0001, 16'hCAFE);
    @(negedge clk);
    check("R6", "stored word", {mem[10'h251], mem[10'h250]}, 16'hCAFE);
    check("R6", "dst step", dst_off, 16'h004E);
    check("R6", "src untouched", src_off, 16'h0099);
    check("R6", "one write", n_wr - w0, 1);
  endtask

  task automatic t_compare;
    int w0 = n_wr;
    mem[10'h160] = 8'h80; mem[10'h260] = 8'h7F;
    go(K_CMP, 0, P_NONE, 0, 16'h0010, 16'h0060, 16'h0020, 16'h0060, 16'h0001, 0);
    check("R7", "greater flags", {flag_cf, flag_zf, flag_sf}, 3'b000);
    mem[10'h161] = 8'h01; mem[10'h261] = 8'h02;
    go(K_CMP, 0, P_NONE, 0, 16'h0010, 16'h0061, 16'h0020, 16'h0061, 16'h0001, 0);
    check("R7", "less flags", {flag_cf, flag_zf, flag_sf}, 3'b101);
    mem[10'h162] = 8'h33; mem[10'h262] = 8'h33;
    go(K_CMP, 0, P_NONE, 0, 16'h0010, 16'h0062, 16'h0020, 16'h0062, 16'h0001, 0);
    check("R7", "equal flags", {flag_cf, flag_zf, flag_sf}, 3'b010);
    check("R7", "both step", {src_off, dst_off}, {16'h0063, 16'h0063});
    check("R7", "no writes", n_wr - w0, 0);
  endtask

  task automatic t_scan_ne;
    int r0 = n_rd;
    mem[10'h270] = 8'h11; mem[10'h271] = 8'h11; mem[10'h272] = 8'h22; mem[10'h273] = 8'h22;
    mem[10'h274] = 8'h77; mem[10'h275] = 8'h77; mem[10'h276] = 8'h77; mem[10'h277] = 8'h77;
    go(K_SCAN, 1, P_NE, 0, 16'h0010, 16'h0011, 16'h0020, 16'h0070, 16'h0005, 16'h7777);
    check("R10", "stop on match count", count, 16'h0002);
    check("R10", "stop on match zf", flag_zf, 1);
    check("R7", "scan dst step", dst_off, 16'h0076);
    check("R7", "scan src untouched", src_off, 16'h0011);
    check("R10", "reads", n_rd - r0, 3);
  endtask

  task automatic t_cmp_eq;
    mem[10'h180] = 8'h41; mem[10'h181] = 8'h42; mem[10'h182] = 8'h10;
    mem[10'h280] = 8'h41; mem[10'h281] = 8'h42; mem[10'h282] = 8'h20;
    go(K_CMP, 0, P_EQ, 0, 16'h0010, 16'h0080, 16'h0020, 16'h0080, 16'h000A, 0);
    check("R10", "stop on mismatch count", count, 16'h0007);
    check("R10", "pointers", {src_off, dst_off}, {16'h0083, 16'h0083});
    check("R7", "mismatch flags", {flag_cf, flag_zf, flag_sf}, 3'b101);
  endtask

  task automatic t_rep_all_scan;
    mem[10'h290] = 8'h55; mem[10'h291] = 8'h55; mem[10'h292] = 8'h55;
    go(K_SCAN, 0, P_ALL, 0, 16'h0010, 0, 16'h0020, 16'h0090, 16'h0003, 16'h0055);
    check("R10", "unconditional ignores zf count", count, 0);
    check("R9", "all iterations", dst_off, 16'h0093);
  endtask

  task automatic t_zero_count;
    int r0 = n_rd;
    int w0 = n_wr;
    go(K_MOVE, 0, P_ALL, 0, 16'h0010, 16'h0005, 16'h0020, 16'h0008, 16'h0000, 0);
    check("R11", "done latency", last_cyc, 1);
    check("R11", "no accesses", (n_rd - r0) + (n_wr - w0), 0);
    check("R11", "pointers unchanged", {src_off, dst_off}, {16'h0005, 16'h0008});
    @(negedge clk);
    check("R12", "done pulse ends", done, 0);
  endtask

  task automatic t_wrap;
    go(K_STORE, 0, P_NONE, 0, 16'h0010, 0, 16'hFFFF, 16'h0020, 16'h0001, 16'h00AB);
    @(negedge clk);
    check("R3", "wrapped address", last_addr, 20'h00010);
    check("R3", "wrapped byte", mem[10'h010], 8'hAB);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_move_byte();
    t_move_word_rep();
    t_load();
    t_store();
    t_compare();
    t_scan_ne();
    t_cmp_eq();
    t_rep_all_scan();
    t_zero_count();
    t_wrap();
    check("R12", "request held while waiting", hold_err, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule